// File: doc/BRIEF.md
# Parallel Life-Rule Grid Engine

This block keeps a rectangular board of one-bit cells (1 = alive, 0 = empty) and, every clock cycle, works out the following generation for all cells at once. It uses the classic two-state birth/survival rule. The successor board is pure combinational logic driven by the present board. It is committed into the present-state register only when a slow generation tick fires. The tick is a one-cycle strobe made by dividing the system clock; at the default setting it fires once per second from a 50 MHz clock.

The starting board is a parameter. A synchronous active-low reset reloads that board and restarts the tick divider. A display or any other consumer reads the board from the `grid` output and can use `tick` to learn when a new generation has been committed.

Top module: `life_engine`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next cycle shows `grid` equal to the `SEED` parameter and `tick` low.
- R2: `tick` is high for exactly one cycle at a time. After reset is released it first goes high on the `TICK_DIV-1`th rising edge. From then on it goes high every `TICK_DIV` cycles.
- R3: `grid` changes only on a rising edge where `tick` is high or reset is asserted. At every other edge it holds its value.
- R4: On a tick, a live cell with two or three live neighbours stays live.
- R5: On a tick, a live cell with zero or one live neighbour becomes empty.
- R6: On a tick, a live cell with four or more live neighbours becomes empty.
- R7: On a tick, an empty cell becomes live if and only if exactly three of its neighbours are live. Otherwise it stays empty.
- R8: Neighbours are the up-to-eight adjacent cells, including diagonal ones. Positions beyond the board's border count as empty, and the board does not wrap around.
- R9: The cell at row r and column c is bit `r*COLS+c` of `grid` and of `SEED`.
- R10: When reset and a tick land on the same edge, reset wins. The board reloads `SEED` rather than the successor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; reloads the seed board |
| tick | output | 1 | One-cycle generation strobe |
| grid | output | ROWS*COLS | Present board, bit r*COLS+c is row r, column c |

## Verification
The bench builds the engine as an 8 by 8 board with `TICK_DIV` set to 6. This lets a few dozen generations run in a few hundred cycles, which would be out of reach with the one-second default. The small board also makes every border and corner cell reachable. The seed holds a glider, a block on the left edge and a horizontal triple on the bottom-right corner. As a result, early generations hit the under-population, crowding, birth and no-wrap border cases, and the later collision hits them again. A reset asserted in the cycle of a pending tick exercises the priority of reset over the commit.

// File: rtl/life_pkg.sv
// life_pkg: shared types and the birth/survival rule for the grid engine.
// Assumes neighbour counts never exceed eight, so four bits hold them.
package life_pkg;

    // Count of live neighbours around one cell (0..8).
    typedef logic [3:0] nbr_cnt_t;

    // Birth/survival decision for one cell given its state and neighbour count.
    function automatic logic life_rule(input logic alive, input nbr_cnt_t cnt);
        logic result;
        if (alive) begin
            result = (cnt == 4'd2) || (cnt == 4'd3);
        end else begin
            result = (cnt == 4'd3);
        end
        return result;
    endfunction

endpackage

// File: rtl/life_tick_gen.sv
// life_tick_gen: free-running divider that emits a registered one-cycle
// strobe every DIV clocks. Assumes DIV >= 3. The counter restarts on the
// strobe, and a synchronous active-low reset clears both counter and strobe.
module life_tick_gen #(
    parameter int unsigned DIV = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = $clog2(DIV);
    localparam logic [CW-1:0] FIRE_AT = CW'(DIV - 2);

    logic [CW-1:0] cnt;

    // Advance the divider and raise the strobe one cycle after the fire point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= (cnt == FIRE_AT);
            cnt  <= tick ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/life_cell.sv
// life_cell: next-state logic for a single cell. Takes the 3x3 window
// around the cell. The window centre must already be forced to zero by
// the caller, and off-board positions must arrive as zero.
module life_cell
    import life_pkg::*;
(
    input  logic       alive,
    input  logic [8:0] window,
    output logic       next
);
    nbr_cnt_t cnt;

    // Add the live neighbours and apply the birth/survival rule.
    always_comb begin
        cnt  = nbr_cnt_t'($countones(window));
        next = life_rule(alive, cnt);
    end
endmodule

// File: rtl/life_next_gen.sv
// life_next_gen: builds the successor board for every cell in parallel.
// Each cell gets a 3x3 window. Positions beyond the border are tied low
// (no wrap), and the centre is tied low so only neighbours are counted.
// Cell (r,c) is bit r*COLS+c.
module life_next_gen #(
    parameter int ROWS = 16,
    parameter int COLS = 16
) (
    input  logic [ROWS*COLS-1:0] cur,
    output logic [ROWS*COLS-1:0] nxt
);
    for (genvar gr = 0; gr < ROWS; gr++) begin : g_row
        for (genvar gc = 0; gc < COLS; gc++) begin : g_col
            logic [8:0] win;
            for (genvar dr = 0; dr < 3; dr++) begin : g_dr
                for (genvar dc = 0; dc < 3; dc++) begin : g_dc
                    localparam int RR = gr + dr - 1;
                    localparam int CC = gc + dc - 1;
                    if ((dr == 1 && dc == 1) || RR < 0 || RR >= ROWS ||
                        CC < 0 || CC >= COLS) begin : g_zero
                        assign win[dr*3+dc] = 1'b0;
                    end else begin : g_tap
                        assign win[dr*3+dc] = cur[RR*COLS+CC];
                    end
                end
            end
            life_cell u_cell (
                .alive  (cur[gr*COLS+gc]),
                .window (win),
                .next   (nxt[gr*COLS+gc])
            );
        end
    end
endmodule

// File: rtl/life_state_reg.sv
// life_state_reg: present-board register. Loads the successor when load is
// high. A synchronous active-low reset reloads the seed and takes
// priority over load.
module life_state_reg #(
    parameter int            W    = 256,
    parameter logic [W-1:0]  SEED = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Hold the board; reseed on reset, commit on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= SEED;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/life_engine.sv
// life_engine: top of the cellular grid engine. Combines the tick divider,
// the parallel successor logic and the board register. Assumes
// TICK_DIV >= 3 and a single clock domain.
module life_engine #(
    parameter int                      ROWS     = 16,
    parameter int                      COLS     = 16,
    parameter int unsigned             TICK_DIV = 50_000_000,
    parameter logic [ROWS*COLS-1:0]    SEED     = (ROWS*COLS)'(64'h00000007_00040002)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic                 tick,
    output logic [ROWS*COLS-1:0] grid
);
    localparam int N = ROWS * COLS;

    logic [N-1:0] successor;

    life_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    life_next_gen #(.ROWS(ROWS), .COLS(COLS)) u_next (
        .cur (grid),
        .nxt (successor)
    );

    life_state_reg #(.W(N), .SEED(SEED)) u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tick),
        .d     (successor),
        .q     (grid)
    );
endmodule

// File: rtl/life_engine_chk.sv
// life_engine_chk: temporal checks on the engine's ports, bound into every
// life_engine instance. It keeps its own gap counter to check the tick
// period without deep $past.
module life_engine_chk #(
    parameter int                   ROWS     = 16,
    parameter int                   COLS     = 16,
    parameter int unsigned          TICK_DIV = 50_000_000,
    parameter logic [ROWS*COLS-1:0] SEED     = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [ROWS*COLS-1:0] grid
);
    int unsigned gap;

    // Count edges since the last tick or reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     gap <= 0;
        else if (tick)  gap <= 0;
        else            gap <= gap + 1;
    end

    // R1 and R10: reset reloads the seed and clears the strobe, even over a tick.
    assert_reset_seed_R1: assert property (@(posedge clk)
        !rst_n |=> (grid == SEED && !tick));

    // R2: strobe is one cycle wide.
    assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R2: strobe spacing.
    assert_tick_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (gap == TICK_DIV - 1));

    // R3: the board holds between ticks.
    assert_grid_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(grid));
endmodule

bind life_engine life_engine_chk #(
    .ROWS(ROWS), .COLS(COLS), .TICK_DIV(TICK_DIV), .SEED(SEED)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .grid  (grid)
);

// File: tb/life_engine_bench.sv
// life_engine_bench: scoreboard bench. The driver pushes predicted boards
// on each tick, and the monitor pops and compares them cell by cell.
module life_engine_bench;
    localparam int          R   = 8;
    localparam int          C   = 8;
    localparam int          N   = R * C;
    localparam int unsigned DIV = 6;
    // glider at top-left, block on left edge, triple on bottom-right corner
    localparam logic [N-1:0] SEED = 64'hE0000303_00070402;

    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] nxt;
    } gen_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick;
    logic [N-1:0] grid;

    gen_t         exp_q[$];
    logic [N-1:0] model;
    int           checks = 0;
    int           fails = 0;
    bit           mon_en = 1'b0;
    bit           done = 1'b0;

    always #10 clk = ~clk;

    life_engine #(.ROWS(R), .COLS(C), .TICK_DIV(DIV), .SEED(SEED)) u_life_engine (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .grid  (grid)
    );

    // Count and report one check.
    task automatic chk(input bit ok, input string req, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Live neighbours of (r,c) on board g, off-board treated as empty.
    function automatic int nbrs(input logic [N-1:0] g, input int r, input int c);
        int n = 0;
        for (int dr = -1; dr <= 1; dr++)
            for (int dc = -1; dc <= 1; dc++)
                if (!(dr == 0 && dc == 0) && r+dr >= 0 && r+dr < R &&
                    c+dc >= 0 && c+dc < C)
                    n += int'(g[(r+dr)*C + (c+dc)]);
        return n;
    endfunction

    // Reference successor board from the birth/survival rules.
    function automatic logic [N-1:0] step(input logic [N-1:0] g);
        logic [N-1:0] s = '0;
        for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++) begin
                int n = nbrs(g, r, c);
                if (g[r*C+c]) s[r*C+c] = (n == 2 || n == 3);
                else          s[r*C+c] = (n == 3);
            end
        return s;
    endfunction

    // Compare every cell of the committed board against the prediction.
    task automatic compare_cells(input gen_t it);
        for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++) begin
                int    n = nbrs(it.prev, r, c);
                bit    a = it.prev[r*C+c];
                string tag;
                if (r == 0 || c == 0 || r == R-1 || c == C-1) tag = "R8";
                else if (a && n < 2)  tag = "R5";
                else if (a && n > 3)  tag = "R6";
                else if (a)           tag = "R4";
                else                  tag = "R7";
                chk(grid[r*C+c] === it.nxt[r*C+c], tag,
                    N'(grid[r*C+c]), N'(it.nxt[r*C+c]));
            end
    endtask

    // Monitor: pop after each tick, otherwise check the board is held.
    logic         prev_tick = 1'b0;
    logic [N-1:0] last_grid = '0;
    bit           prev_en = 1'b0;
    always @(negedge clk) begin
        if (mon_en && prev_en) begin
            if (prev_tick) begin
                if (exp_q.size() == 0) chk(1'b0, "R3", grid, '0);
                else begin
                    gen_t it;
                    it = exp_q.pop_front();
                    compare_cells(it);
                end
            end else begin
                chk(grid === last_grid, "R3", grid, last_grid);
            end
        end
        prev_tick = tick;
        last_grid = grid;
        prev_en   = mon_en;
    end

    // Wait for the next tick, returning the number of falling edges waited.
    task automatic wait_tick(output int gap);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (tick !== 1'b1);
    endtask

    // Driver: check tick spacing (R2) and push the predicted successor.
    task automatic run_gens(input int n);
        for (int i = 0; i < n; i++) begin
            int   gap;
            int   want;
            gen_t it;
            wait_tick(gap);
            want = (i == 0) ? int'(DIV) - 1 : int'(DIV);
            chk(gap == want, "R2", N'(gap), N'(want));
            it.prev = model;
            it.nxt  = step(model);
            exp_q.push_back(it);
            model = it.nxt;
        end
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        int rr[12] = '{0, 1, 2, 2, 2, 4, 4, 5, 5, 7, 7, 7};
        int cc[12] = '{1, 2, 0, 1, 2, 0, 1, 0, 1, 5, 6, 7};
        int gap;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(grid === SEED, "R1", grid, SEED);
        chk(tick === 1'b0, "R1", N'(tick), '0);
        // R9: coordinate mapping of seed cells
        for (int k = 0; k < 12; k++)
            chk(grid[rr[k]*C + cc[k]] === 1'b1, "R9", N'(grid[rr[k]*C + cc[k]]), N'(1));
        chk($countones(grid) == 12, "R9", N'($countones(grid)), N'(12));
        model  = SEED;
        rst_n  = 1'b1;
        mon_en = 1'b1;
        run_gens(24);
        // R10: reset on the same edge as a pending commit
        wait_tick(gap);
        chk(gap == int'(DIV), "R2", N'(gap), N'(DIV));
        mon_en = 1'b0;
        rst_n  = 1'b0;
        @(negedge clk);
        chk(grid === SEED, "R10", grid, SEED);
        chk(tick === 1'b0, "R10", N'(tick), '0);
        exp_q.delete();
        model  = SEED;
        rst_n  = 1'b1;
        mon_en = 1'b1;
        run_gens(8);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R3", N'(exp_q.size()), '0);
        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end
endmodule